// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value held in an unpacked working form and produces the 32-bit IEEE single-precision word for it. The working form has a sign, a two-bit class, a signed unbiased exponent, and a 26-bit significand. The significand holds the explicit leading one, 23 fraction bits, then a guard bit and a round bit. A separate sticky bit completes it. The block rounds the value under one of four rounding directions and folds the result into the packed layout. It also raises the overflow, underflow and inexact flags that belong to that rounding.

A value too small for a normal result is first shifted down into the subnormal range. The bits it loses go into the sticky bit. Only after that shift is it rounded. Such a value may round up into the smallest normal number. A result that is too large saturates to infinity or to the largest finite magnitude, depending on the rounding direction and the sign. The datapath is combinational and ends in one output register, so each result appears one clock after its operands are presented.

Top module: `fp_single_packer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the output word and all three flags are zero.
- R2: The output word and flags reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R3: Class code 0 (zero) yields the sign in bit 31 and zeros elsewhere, with no flag set, whatever the exponent, significand, sticky or mode inputs hold.
- R4: Class code 2 (infinity) yields the sign, exponent field 255 and fraction 0, with no flag set.
- R5: Class code 3 (NaN) yields the sign, exponent field 255 and fraction equal to significand bits [24:2], with no flag set and no rounding.
- R6: For class code 1 (number) with exponent plus 127 at least 1, the exponent field is exponent plus 127 and the fraction is significand bits [24:2] rounded. Guard is bit 1 and round is bit 0. Inexact is set when guard, round or sticky is set. Mode 0 rounds to nearest, mode 1 toward zero, mode 2 toward plus infinity and mode 3 toward minus infinity.
- R7: In mode 0, a discarded part of exactly one half (guard set, round and sticky clear) rounds up only when the kept fraction is odd.
- R8: When rounding carries a normal significand to 2.0, the exponent field increases by one and the fraction becomes 0.
- R9: A final exponent of 255 or more sets overflow and inexact. The result is infinity in mode 0, in mode 2 when positive and in mode 3 when negative; otherwise it is exponent 254 with an all-ones fraction, with the sign kept.
- R10: When exponent plus 127 is 0 or less, the significand is shifted right by 1 minus that sum before rounding, with shifted-out bits ORed into sticky. The result has exponent field 0.
- R11: A subnormal whose rounding reaches the implicit-bit position gives exponent field 1 and fraction 0, without underflow.
- R12: A result that stays subnormal sets underflow when it is inexact, or when the underflow-trap enable is set even though the result is exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| in_sign | input | 1 | Sign of the value, 1 for negative |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_exp | input | IN_EXP_W (10) | Signed unbiased exponent |
| in_mant | input | FRAC_W+3 (26) | Leading one, fraction, guard, round |
| in_sticky | input | 1 | OR of all bits below the round bit |
| rnd_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| uf_trap_en | input | 1 | Underflow trap enable; forces underflow on exact tiny results |
| out_word | output | 1+EXPF_W+FRAC_W (32) | Packed single-precision word |
| out_overflow | output | 1 | Overflow flag |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The bound checker watches relations that must hold on any cycle. Overflow always comes with inexact and an exponent field of 254 or 255. Underflow always comes with a zero exponent field and never with overflow. The sign passes through one cycle later. Zero, infinity and NaN inputs pack to their fixed shapes with no flags, and outputs are clear right after reset. Numeric correctness depends on specific operands, so only the bench's directed scenarios can show it. These cover the tie-to-even decisions, the carry into the next binade, the choice between infinity and the largest finite value, the largest subnormal rounding into the smallest normal, and sticky gathering on deep shifts.

// File: rtl/pk_pkg.sv
package pk_pkg;
   typedef enum logic [1:0] {
      CLS_ZERO = 2'd0,
      CLS_NUM  = 2'd1,
      CLS_INF  = 2'd2,
      CLS_NAN  = 2'd3
   } pk_class_e;

   typedef enum logic [1:0] {
      RM_NEAR = 2'd0,
      RM_ZERO = 2'd1,
      RM_UP   = 2'd2,
      RM_DOWN = 2'd3
   } pk_rmode_e;
endpackage

// File: rtl/pk_align.sv
// Right shift of the significand into the subnormal range; lost bits feed sticky.
module pk_align #(
   parameter int MANT_W = 26,
   parameter int SH_W   = 12
) (
   input  logic [MANT_W-1:0] mant,
   input  logic              sticky_in,
   input  logic [SH_W-1:0]   shamt,
   output logic [MANT_W-1:0] shifted,
   output logic              sticky_out
);
   localparam int WIDE_W = 2 * MANT_W;

   logic [WIDE_W-1:0] wide;

   always_comb begin
      wide = {mant, {MANT_W{1'b0}}} >> shamt;
      if (shamt >= SH_W'(MANT_W)) begin
         shifted    = '0;
         sticky_out = (|mant) | sticky_in;
      end else begin
         shifted    = wide[WIDE_W-1:MANT_W];
         sticky_out = (|wide[MANT_W-1:0]) | sticky_in;
      end
   end
endmodule

// File: rtl/pk_rounder.sv
// Guard/round/sticky rounding of a W-bit significand; one extra bit holds the carry.
module pk_rounder #(
   parameter int W = 24
) (
   input  logic [W-1:0] sig,
   input  logic         guard,
   input  logic         rbit,
   input  logic         sticky,
   input  logic         sign,
   input  logic [1:0]   rm,
   output logic [W:0]   rounded,
   output logic         inexact
);
   import pk_pkg::*;

   logic up;

   always_comb begin
      inexact = guard | rbit | sticky;
      case (pk_rmode_e'(rm))
         RM_NEAR: up = guard & (rbit | sticky | sig[0]);
         RM_ZERO: up = 1'b0;
         RM_UP:   up = inexact & ~sign;
         default: up = inexact & sign;
      endcase
      rounded = {1'b0, sig} + (W+1)'(up);
   end
endmodule

// File: rtl/pk_ovf_select.sv
// Decides whether an overflowing result saturates to infinity.
module pk_ovf_select (
   input  logic       sign,
   input  logic [1:0] rm,
   output logic       to_inf
);
   import pk_pkg::*;

   always_comb begin
      case (pk_rmode_e'(rm))
         RM_NEAR: to_inf = 1'b1;
         RM_ZERO: to_inf = 1'b0;
         RM_UP:   to_inf = ~sign;
         default: to_inf = sign;
      endcase
   end
endmodule

// File: rtl/fp_single_packer.sv
module fp_single_packer #(
   parameter int FRAC_W   = 23,
   parameter int EXPF_W   = 8,
   parameter int IN_EXP_W = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_sign,
   input  logic [1:0]                 in_class,
   input  logic [IN_EXP_W-1:0]        in_exp,
   input  logic [FRAC_W+2:0]          in_mant,
   input  logic                       in_sticky,
   input  logic [1:0]                 rnd_mode,
   input  logic                       uf_trap_en,
   output logic [EXPF_W+FRAC_W:0]     out_word,
   output logic                       out_overflow,
   output logic                       out_underflow,
   output logic                       out_inexact
);
   import pk_pkg::*;

   localparam int MANT_W  = FRAC_W + 3;
   localparam int SIG_W   = FRAC_W + 1;
   localparam int BE_W    = IN_EXP_W + 2;
   localparam int BIAS    = (1 << (EXPF_W - 1)) - 1;
   localparam int EXP_MAX = (1 << EXPF_W) - 1;
   localparam int WORD_W  = 1 + EXPF_W + FRAC_W;

   generate
      if (FRAC_W < 2) begin : g_bad_frac
         $error("FRAC_W must be at least 2");
      end
      if (EXPF_W < 2) begin : g_bad_expf
         $error("EXPF_W must be at least 2");
      end
      if (IN_EXP_W <= EXPF_W) begin : g_bad_inexp
         $error("IN_EXP_W must exceed EXPF_W");
      end
   endgenerate

   // biased exponent and path selection
   logic signed [BE_W-1:0] biased;
   logic signed [BE_W-1:0] exp_n;
   logic        [BE_W-1:0] shamt;
   logic                   is_sub;

   assign biased = $signed({{2{in_exp[IN_EXP_W-1]}}, in_exp}) + $signed(BE_W'(BIAS));
   assign is_sub = (biased <= 0);
   assign shamt  = BE_W'(1) - biased;

   logic [MANT_W-1:0] al_mant;
   logic              al_sticky;

   pk_align #(.MANT_W(MANT_W), .SH_W(BE_W)) u_align (
      .mant       (in_mant),
      .sticky_in  (in_sticky),
      .shamt      (shamt),
      .shifted    (al_mant),
      .sticky_out (al_sticky)
   );

   logic [MANT_W-1:0] sel_mant;
   logic              sel_sticky;

   assign sel_mant   = is_sub ? al_mant   : in_mant;
   assign sel_sticky = is_sub ? al_sticky : in_sticky;

   logic [SIG_W:0] rounded;
   logic           rnd_nx;

   pk_rounder #(.W(SIG_W)) u_round (
      .sig     (sel_mant[MANT_W-1:2]),
      .guard   (sel_mant[1]),
      .rbit    (sel_mant[0]),
      .sticky  (sel_sticky),
      .sign    (in_sign),
      .rm      (rnd_mode),
      .rounded (rounded),
      .inexact (rnd_nx)
   );

   logic to_inf;

   pk_ovf_select u_ovf (
      .sign   (in_sign),
      .rm     (rnd_mode),
      .to_inf (to_inf)
   );

   // carry into the next binade on the normal path
   logic carry;
   logic ovf;

   assign carry = rounded[SIG_W];
   assign exp_n = biased + $signed({{(BE_W-1){1'b0}}, carry});
   assign ovf   = (exp_n >= $signed(BE_W'(EXP_MAX)));

   logic [WORD_W-1:0] nx_word;
   logic              nx_of, nx_uf, nx_nx;
   logic              sub_bump;

   assign sub_bump = rounded[FRAC_W];

   always_comb begin
      nx_word = '0;
      nx_of   = 1'b0;
      nx_uf   = 1'b0;
      nx_nx   = 1'b0;
      case (pk_class_e'(in_class))
         CLS_ZERO: nx_word = {in_sign, {(EXPF_W+FRAC_W){1'b0}}};
         CLS_INF:  nx_word = {in_sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
         CLS_NAN:  nx_word = {in_sign, {EXPF_W{1'b1}}, in_mant[MANT_W-2:2]};
         default: begin
            nx_nx = rnd_nx;
            if (is_sub) begin
               nx_word = {in_sign, (EXPF_W)'(sub_bump), rounded[FRAC_W-1:0]};
               nx_uf   = ~sub_bump & (rnd_nx | uf_trap_en);
            end else if (ovf) begin
               nx_of = 1'b1;
               nx_nx = 1'b1;
               if (to_inf)
                  nx_word = {in_sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
               else
                  nx_word = {in_sign, {(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
            end else begin
               nx_word = {in_sign, exp_n[EXPF_W-1:0], rounded[FRAC_W-1:0]};
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_word      <= '0;
         out_overflow  <= 1'b0;
         out_underflow <= 1'b0;
         out_inexact   <= 1'b0;
      end else begin
         out_word      <= nx_word;
         out_overflow  <= nx_of;
         out_underflow <= nx_uf;
         out_inexact   <= nx_nx;
      end
   end
endmodule

// File: rtl/fp_single_packer_chk.sv
module fp_single_packer_chk #(
   parameter int FRAC_W   = 23,
   parameter int EXPF_W   = 8,
   parameter int IN_EXP_W = 10
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_sign,
   input logic [1:0]             in_class,
   input logic [EXPF_W+FRAC_W:0] out_word,
   input logic                   out_overflow,
   input logic                   out_underflow,
   input logic                   out_inexact
);
   localparam int EXP_MAX = (1 << EXPF_W) - 1;

   logic [EXPF_W-1:0] ef;
   logic [FRAC_W-1:0] ff;
   logic              flags_any;

   assign ef        = out_word[FRAC_W +: EXPF_W];
   assign ff        = out_word[FRAC_W-1:0];
   assign flags_any = out_overflow | out_underflow | out_inexact;

   assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (out_word == '0 && !flags_any));

   assert_sign_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_word[EXPF_W+FRAC_W] == $past(in_sign)));

   assert_zero_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_class) == 2'd0) |-> (out_word[EXPF_W+FRAC_W-1:0] == '0 && !flags_any));

   assert_inf_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_class) == 2'd2) |-> (ef == EXPF_W'(EXP_MAX) && ff == '0 && !flags_any));

   assert_nan_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_class) == 2'd3) |-> (ef == EXPF_W'(EXP_MAX) && !flags_any));

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_overflow |-> (out_inexact && !out_underflow &&
                        (ef == EXPF_W'(EXP_MAX) ||
                         (ef == EXPF_W'(EXP_MAX - 1) && ff == '1))));

   assert_underflow_tiny_R12: assert property (@(posedge clk) disable iff (!rst_n)
      out_underflow |-> (ef == '0 && !out_overflow));
endmodule

bind fp_single_packer fp_single_packer_chk #(
   .FRAC_W(FRAC_W), .EXPF_W(EXPF_W), .IN_EXP_W(IN_EXP_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_sign       (in_sign),
   .in_class      (in_class),
   .out_word      (out_word),
   .out_overflow  (out_overflow),
   .out_underflow (out_underflow),
   .out_inexact   (out_inexact)
);

// File: tb/fp_single_packer_test.sv
`timescale 1ns/1ps
module fp_single_packer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_sign = 1'b0;
   logic [1:0]  in_class = 2'd0;
   logic [9:0]  in_exp = '0;
   logic [25:0] in_mant = '0;
   logic        in_sticky = 1'b0;
   logic [1:0]  rnd_mode = 2'd0;
   logic        uf_trap_en = 1'b0;
   logic [31:0] out_word;
   logic        out_overflow, out_underflow, out_inexact;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   fp_single_packer uut (
      .clk(clk), .rst_n(rst_n), .in_sign(in_sign), .in_class(in_class),
      .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
      .rnd_mode(rnd_mode), .uf_trap_en(uf_trap_en), .out_word(out_word),
      .out_overflow(out_overflow), .out_underflow(out_underflow),
      .out_inexact(out_inexact)
   );

   // {req(4), sign, class(2), exp(10), mant(26), sticky, mode(2), trap, word(32), of, uf, nx}
   localparam int NV = 38;
   localparam logic [81:0] VEC [NV] = '{
      {4'd6,  1'b0, 2'd1, 10'sd0,    26'h2000000, 1'b0, 2'd0, 1'b0, 32'h3F800000, 3'b000}, // R6 one
      {4'd6,  1'b1, 2'd1, 10'sd0,    26'h3000000, 1'b0, 2'd0, 1'b0, 32'hBFC00000, 3'b000}, // R6 -1.5
      {4'd7,  1'b0, 2'd1, 10'sd0,    26'h2000002, 1'b0, 2'd0, 1'b0, 32'h3F800000, 3'b001}, // R7 tie even
      {4'd7,  1'b0, 2'd1, 10'sd0,    26'h2000006, 1'b0, 2'd0, 1'b0, 32'h3F800002, 3'b001}, // R7 tie odd
      {4'd6,  1'b0, 2'd1, 10'sd0,    26'h2000003, 1'b0, 2'd0, 1'b0, 32'h3F800001, 3'b001}, // R6 above half
      {4'd6,  1'b0, 2'd1, 10'sd0,    26'h2000007, 1'b0, 2'd1, 1'b0, 32'h3F800001, 3'b001}, // R6 toward zero
      {4'd6,  1'b0, 2'd1, 10'sd0,    26'h2000000, 1'b1, 2'd2, 1'b0, 32'h3F800001, 3'b001}, // R6 +inf pos
      {4'd6,  1'b1, 2'd1, 10'sd0,    26'h2000000, 1'b1, 2'd2, 1'b0, 32'hBF800000, 3'b001}, // R6 +inf neg
      {4'd6,  1'b1, 2'd1, 10'sd0,    26'h2000000, 1'b1, 2'd3, 1'b0, 32'hBF800001, 3'b001}, // R6 -inf neg
      {4'd6,  1'b0, 2'd1, 10'sd0,    26'h2000000, 1'b1, 2'd3, 1'b0, 32'h3F800000, 3'b001}, // R6 -inf pos
      {4'd8,  1'b0, 2'd1, 10'sd0,    26'h3FFFFFE, 1'b0, 2'd0, 1'b0, 32'h40000000, 3'b001}, // R8 carry
      {4'd6,  1'b0, 2'd1, 10'sd127,  26'h3FFFFFC, 1'b0, 2'd0, 1'b0, 32'h7F7FFFFF, 3'b000}, // R6 max finite
      {4'd9,  1'b0, 2'd1, 10'sd127,  26'h3FFFFFE, 1'b0, 2'd0, 1'b0, 32'h7F800000, 3'b101}, // R9 carry ovf
      {4'd6,  1'b0, 2'd1, 10'sd127,  26'h3FFFFFE, 1'b0, 2'd1, 1'b0, 32'h7F7FFFFF, 3'b001}, // R6 no carry rz
      {4'd6,  1'b1, 2'd1, 10'sd127,  26'h3FFFFFE, 1'b0, 2'd2, 1'b0, 32'hFF7FFFFF, 3'b001}, // R6 no carry neg
      {4'd9,  1'b0, 2'd1, 10'sd127,  26'h3FFFFFE, 1'b0, 2'd2, 1'b0, 32'h7F800000, 3'b101}, // R9 carry up
      {4'd9,  1'b0, 2'd1, 10'sd128,  26'h2000000, 1'b0, 2'd2, 1'b0, 32'h7F800000, 3'b101}, // R9
      {4'd9,  1'b1, 2'd1, 10'sd128,  26'h2000000, 1'b0, 2'd2, 1'b0, 32'hFF7FFFFF, 3'b101}, // R9
      {4'd9,  1'b1, 2'd1, 10'sd128,  26'h2000000, 1'b0, 2'd3, 1'b0, 32'hFF800000, 3'b101}, // R9
      {4'd9,  1'b0, 2'd1, 10'sd128,  26'h2000000, 1'b0, 2'd3, 1'b0, 32'h7F7FFFFF, 3'b101}, // R9
      {4'd9,  1'b0, 2'd1, 10'sd128,  26'h2000000, 1'b0, 2'd1, 1'b0, 32'h7F7FFFFF, 3'b101}, // R9
      {4'd9,  1'b1, 2'd1, 10'sd128,  26'h2000000, 1'b0, 2'd0, 1'b0, 32'hFF800000, 3'b101}, // R9
      {4'd6,  1'b0, 2'd1, -10'sd126, 26'h2000000, 1'b0, 2'd0, 1'b0, 32'h00800000, 3'b000}, // R6 min normal
      {4'd10, 1'b0, 2'd1, -10'sd127, 26'h2000000, 1'b0, 2'd0, 1'b0, 32'h00400000, 3'b000}, // R10 exact sub
      {4'd12, 1'b0, 2'd1, -10'sd127, 26'h2000000, 1'b0, 2'd0, 1'b1, 32'h00400000, 3'b010}, // R12 trap
      {4'd11, 1'b0, 2'd1, -10'sd127, 26'h3FFFFFC, 1'b0, 2'd0, 1'b0, 32'h00800000, 3'b001}, // R11 bump
      {4'd11, 1'b1, 2'd1, -10'sd127, 26'h3FFFFFC, 1'b0, 2'd3, 1'b1, 32'h80800000, 3'b001}, // R11 bump neg
      {4'd12, 1'b0, 2'd1, -10'sd127, 26'h3FFFFFC, 1'b0, 2'd1, 1'b0, 32'h007FFFFF, 3'b011}, // R12 inexact
      {4'd10, 1'b0, 2'd1, -10'sd127, 26'h3FFFFF8, 1'b0, 2'd0, 1'b0, 32'h007FFFFF, 3'b000}, // R10 max sub
      {4'd12, 1'b0, 2'd1, -10'sd200, 26'h2000000, 1'b0, 2'd2, 1'b0, 32'h00000001, 3'b011}, // R12 deep up
      {4'd12, 1'b0, 2'd1, -10'sd200, 26'h2000000, 1'b0, 2'd0, 1'b0, 32'h00000000, 3'b011}, // R12 deep
      {4'd10, 1'b0, 2'd1, -10'sd149, 26'h2000000, 1'b0, 2'd0, 1'b0, 32'h00000001, 3'b000}, // R10 min sub
      {4'd10, 1'b1, 2'd1, -10'sd150, 26'h2000000, 1'b0, 2'd0, 1'b0, 32'h80000000, 3'b011}, // R10 tie even
      {4'd10, 1'b0, 2'd1, -10'sd150, 26'h2000001, 1'b0, 2'd0, 1'b0, 32'h00000001, 3'b011}, // R10 sticky
      {4'd3,  1'b1, 2'd0, 10'sd5,    26'h1234567, 1'b1, 2'd2, 1'b1, 32'h80000000, 3'b000}, // R3
      {4'd4,  1'b0, 2'd2, 10'sd0,    26'h2000000, 1'b0, 2'd0, 1'b0, 32'h7F800000, 3'b000}, // R4
      {4'd4,  1'b1, 2'd2, 10'sd0,    26'h2000000, 1'b1, 2'd3, 1'b1, 32'hFF800000, 3'b000}, // R4 neg
      {4'd5,  1'b0, 2'd3, 10'sd0,    26'h3000004, 1'b1, 2'd2, 1'b1, 32'h7FC00001, 3'b000}  // R5
   };

   task automatic check(input int req, input logic [31:0] exp_w, input logic [2:0] exp_f);
      n_checks++;
      if (out_word !== exp_w || {out_overflow, out_underflow, out_inexact} !== exp_f) begin
         n_errors++;
         $display("FAIL R%0d: got word=%h flags=%b expected word=%h flags=%b",
                  req, out_word, {out_overflow, out_underflow, out_inexact}, exp_w, exp_f);
      end
   endtask

   task automatic drive(input logic [81:0] v);
      in_sign    = v[77];
      in_class   = v[76:75];
      in_exp     = v[74:65];
      in_mant    = v[64:39];
      in_sticky  = v[38];
      rnd_mode   = v[37:36];
      uf_trap_en = v[35];
   endtask

   initial begin
      // R1: reset state, inputs present a non-zero value
      drive(VEC[1]);
      @(negedge clk);
      @(negedge clk);
      check(1, 32'h0, 3'b000);
      rst_n = 1'b1;

      // main table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i]);
         @(negedge clk);
         check(int'(VEC[i][81:78]), VEC[i][34:3], VEC[i][2:0]);
      end

      // R2: output holds until the next edge
      @(negedge clk);
      drive(VEC[0]);
      @(negedge clk);
      drive(VEC[10]);
      #3;
      check(2, 32'h3F800000, 3'b000);
      @(negedge clk);
      check(2, 32'h40000000, 3'b001);

      // R1: reset asserted mid-run clears a flagged result
      drive(VEC[12]);
      @(negedge clk);
      check(9, 32'h7F800000, 3'b101);
      rst_n = 1'b0;
      @(negedge clk);
      check(1, 32'h0, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);
      check(9, 32'h7F800000, 3'b101);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule